// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Access Sequencer

This block turns one processor access into a flash window into one whole serial flash transaction. The access address holds a window index and an offset. Each chip-select line owns a window of 2^WIN_BITS bytes, 128 MiB by default. The sequencer pulls the chosen select low and emits a stream of bytes on a byte-level transfer port. For a read, the stream is an opcode, the address, a number of zero-valued dummy transfers, and then the data bytes. For a write, the stream is an opcode, the address and then the payload. The select is released once the last byte has been sent.

Two configuration words come in as inputs, one for reads and one for writes. They set the opcode, the address width and, for reads only, the dummy count. The block decodes these words at the moment it accepts a request and holds the result for the rest of that transaction.

An address-width code that is not supported skips the address phase and raises an error pulse. A second input tells the block that some other agent is already holding a select on the shared bus. A request accepted while that input is high raises a collision pulse, but the transaction still runs. The bit-level shifter, caching and prefetch are outside this block.

Top module: `flash_window_seq`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, xfer_start_o is 0, and every cs_n_o bit is 1.
- R2: The window index req_addr_i[ADDR_W-1:WIN_BITS] selects the single cs_n_o bit that is driven low for every byte of the transaction. All other bits stay high. All bits are high again in the rsp_valid_o cycle.
- R3: A read (req_we_i=0) sends rd_cfg_i[7:0] first, then the address, then the dummy transfers, then one transfer per data byte.
- R4: The address-size code is bits [17:16] of the config word in use. Code 0 sends offset bytes [23:16], [15:8], [7:0]. Code 1 sends bytes [31:24] down to [7:0]. The offset is zero-extended to 32 bits and sent most significant byte first. Codes 2 and 3 send no address, and addr_err_o is high for exactly the cycle after acceptance.
- R5: A read sends ((rd_cfg_i[13:12]*8) >> rd_cfg_i[9:8]) dummy transfers with value 0x00.
- R6: A write sends wr_cfg_i[7:0], then the address per wr_cfg_i[17:16], then the payload. It has no dummy phase, whatever rd_cfg_i holds.
- R7: req_len_i holds the byte count minus one (0..7 means 1..8 bytes). Write byte i is req_wdata_i[8i+7:8i] and is sent i-th. Received data byte i lands in rsp_rdata_o[8i+7:8i]. Bytes not received, and all bytes of a write response, read as 0.
- R8: If shared_cs_busy_i is 1 in the accepting cycle, busy_err_o is high for exactly the next cycle, and the transaction proceeds unchanged.
- R9: Each byte uses exactly one single-cycle xfer_start_o pulse. The next pulse comes only after xfer_done_i has been seen for the current byte. xfer_rx_i is captured only for read data bytes.
- R10: req_ready_o drops from acceptance until the response. rsp_valid_o is high for one cycle after the last byte's done, and req_ready_o is back to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Sequencer idle, request accepted this cycle |
| req_addr_i | input | ADDR_W | Window index and window offset |
| req_len_i | input | LEN_W | Byte count minus one |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 8*MAX_BYTES | Write payload, little-endian |
| rsp_valid_o | output | 1 | Transaction finished |
| rsp_rdata_o | output | 8*MAX_BYTES | Read data, little-endian |
| rd_cfg_i | input | 32 | Read configuration word |
| wr_cfg_i | input | 32 | Write configuration word |
| shared_cs_busy_i | input | 1 | Another agent holds a chip select |
| xfer_start_o | output | 1 | Start one byte transfer |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_done_i | input | 1 | Byte transfer finished |
| xfer_rx_i | input | 8 | Byte received, valid with done |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| addr_err_o | output | 1 | Unsupported address-size code pulse |
| busy_err_o | output | 1 | Select collision pulse |

## Verification
Most faults in the state register or the byte counter show up on the wire at the next transfer start. Typical symptoms are an opcode, address byte or dummy that is missing, repeated or out of order, or a select on the wrong line. The bench compares every transferred byte, and the select seen with it, against an expected stream at the moment the start pulse appears. A wrong capture index or a missed clear of the read lanes only shows in the response data, one cycle after the final done. Plan decoding faults show either in the byte stream or in the error pulse one cycle after acceptance.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int CFG_W      = 32;
  localparam int OPC_LSB    = 0;
  localparam int ACC_LSB    = 8;
  localparam int DBW_LSB    = 12;
  localparam int ASZ_LSB    = 16;
  localparam int CNT_W      = 5;   // holds up to 24 dummies and 8 data bytes
  localparam int ABYTES_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_RESP
  } fws_state_e;

  typedef struct packed {
    logic [7:0]          opcode;
    logic [ABYTES_W-1:0] addr_bytes;
    logic [CNT_W-1:0]    dummies;
    logic                bad_asz;
  } fws_plan_t;
endpackage

// File: rtl/fws_plan.sv
module fws_plan
  import fws_pkg::*;
(
  input  logic [CFG_W-1:0] rd_cfg_i,
  input  logic [CFG_W-1:0] wr_cfg_i,
  input  logic             we_i,
  output fws_plan_t        plan_o
);
  logic [CFG_W-1:0] cfg;
  logic [1:0]       asz;
  logic [1:0]       dbw;
  logic [1:0]       acc;
  logic [CNT_W-1:0] dbits;

  always_comb begin
    cfg   = we_i ? wr_cfg_i : rd_cfg_i;
    asz   = cfg[ASZ_LSB +: 2];
    dbw   = rd_cfg_i[DBW_LSB +: 2];
    acc   = rd_cfg_i[ACC_LSB +: 2];
    dbits = {dbw, 3'b000};
    plan_o.opcode = cfg[OPC_LSB +: 8];
    plan_o.bad_asz = 1'b0;
    unique case (asz)
      2'd0:    plan_o.addr_bytes = 3'd3;
      2'd1:    plan_o.addr_bytes = 3'd4;
      default: begin
        plan_o.addr_bytes = 3'd0;
        plan_o.bad_asz    = 1'b1;
      end
    endcase
    plan_o.dummies = we_i ? '0 : (dbits >> acc);
  end
endmodule

// File: rtl/fws_cs_decode.sv
module fws_cs_decode #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              active_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_n_o[g] = ~(active_i && (idx_i == IDX_W'(g)));
  end
endmodule

// File: rtl/fws_lane.sv
module fws_lane #(
  parameter int MAX_BYTES = 8,
  localparam int DW    = 8 * MAX_BYTES,
  localparam int IDX_W = $clog2(MAX_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             capture_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       rx_i,
  output logic [7:0]       tx_o,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_q <= '0;
    else if (load_i) wdata_q <= wdata_i;
  end

  assign tx_o = wdata_q[8*idx_i +: 8];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] rb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  rb_q <= '0;
      else if (load_i)                              rb_q <= '0;
      else if (capture_i && idx_i == IDX_W'(g))     rb_q <= rx_i;
    end
    assign rdata_o[8*g +: 8] = rb_q;
  end
endmodule

// File: rtl/flash_window_seq.sv
module flash_window_seq
  import fws_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int WIN_BITS  = 27,
  parameter int MAX_BYTES = 8,
  localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int ADDR_W = WIN_BITS + IDX_W,
  localparam int LEN_W  = $clog2(MAX_BYTES),
  localparam int DW     = 8 * MAX_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_we_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic [CFG_W-1:0]  rd_cfg_i,
  input  logic [CFG_W-1:0]  wr_cfg_i,
  input  logic              shared_cs_busy_i,
  output logic              xfer_start_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_rx_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              addr_err_o,
  output logic              busy_err_o
);
  fws_state_e       state_q, state_d;
  logic             pending_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      off_q;
  logic [LEN_W-1:0] len_q;
  logic             we_q;
  logic [IDX_W-1:0] idx_q;
  logic             cs_act_q;
  fws_plan_t        plan_new, plan_q;
  logic             addr_err_q, busy_err_q;
  logic             accept, byte_phase, byte_done, capture;
  logic [7:0]       lane_tx;

  fws_plan u_plan (
    .rd_cfg_i (rd_cfg_i),
    .wr_cfg_i (wr_cfg_i),
    .we_i     (req_we_i),
    .plan_o   (plan_new)
  );

  assign accept     = (state_q == ST_IDLE) && req_valid_i;
  assign byte_phase = (state_q == ST_OPC) || (state_q == ST_ADDR) ||
                      (state_q == ST_DUMMY) || (state_q == ST_DATA);
  assign byte_done  = byte_phase && pending_q && xfer_done_i;
  assign capture    = byte_done && (state_q == ST_DATA) && !we_q;

  // next phase after the address (or after the opcode when no address)
  function automatic void after_addr(input fws_plan_t p, input logic we,
                                     output fws_state_e st, output logic [CNT_W-1:0] c);
    if (!we && p.dummies != '0) begin
      st = ST_DUMMY;
      c  = p.dummies - CNT_W'(1);
    end else begin
      st = ST_DATA;
      c  = '0;
    end
  endfunction

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_OPC;
      ST_OPC: if (byte_done) begin
        if (plan_q.addr_bytes != '0) begin
          state_d = ST_ADDR;
          cnt_d   = CNT_W'(plan_q.addr_bytes) - CNT_W'(1);
        end else begin
          after_addr(plan_q, we_q, state_d, cnt_d);
        end
      end
      ST_ADDR: if (byte_done) begin
        if (cnt_q == '0) after_addr(plan_q, we_q, state_d, cnt_d);
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      ST_DUMMY: if (byte_done) begin
        if (cnt_q == '0) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_DATA: if (byte_done) begin
        if (cnt_q == CNT_W'(len_q)) state_d = ST_RESP;
        else                        cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pending_q  <= 1'b0;
      cnt_q      <= '0;
      off_q      <= '0;
      len_q      <= '0;
      we_q       <= 1'b0;
      idx_q      <= '0;
      cs_act_q   <= 1'b0;
      plan_q     <= '0;
      addr_err_q <= 1'b0;
      busy_err_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      addr_err_q <= accept && plan_new.bad_asz;
      busy_err_q <= accept && shared_cs_busy_i;
      if (xfer_start_o)   pending_q <= 1'b1;
      else if (byte_done) pending_q <= 1'b0;
      if (accept) begin
        off_q    <= 32'(req_addr_i[WIN_BITS-1:0]);
        idx_q    <= req_addr_i[ADDR_W-1:WIN_BITS];
        len_q    <= req_len_i;
        we_q     <= req_we_i;
        plan_q   <= plan_new;
        cs_act_q <= 1'b1;
        pending_q <= 1'b0;
      end else if (state_d == ST_RESP) begin
        cs_act_q <= 1'b0;
      end
    end
  end

  fws_lane #(.MAX_BYTES(MAX_BYTES)) u_lane (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .idx_i     (cnt_q[LEN_W-1:0]),
    .rx_i      (xfer_rx_i),
    .tx_o      (lane_tx),
    .rdata_o   (rsp_rdata_o)
  );

  fws_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .idx_i    (idx_q),
    .active_i (cs_act_q),
    .cs_n_o   (cs_n_o)
  );

  always_comb begin
    unique case (state_q)
      ST_OPC:  xfer_tx_o = plan_q.opcode;
      ST_ADDR: xfer_tx_o = off_q[8*cnt_q[1:0] +: 8];
      ST_DATA: xfer_tx_o = we_q ? lane_tx : 8'h00;
      default: xfer_tx_o = 8'h00;
    endcase
  end

  assign xfer_start_o = byte_phase && !pending_q;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign addr_err_o   = addr_err_q;
  assign busy_err_o   = busy_err_q;

  assert_cs_onehot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);
  assert_start_has_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (cs_n_o != {NUM_CS{1'b1}}));
  assert_rsp_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (cs_n_o == {NUM_CS{1'b1}}));
  assert_start_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  assert_hold_until_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_o && !xfer_done_i && $past(xfer_start_o)) |=> !xfer_start_o);
  assert_ready_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_rsp_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  assert_err_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |=> !addr_err_o);
  assert_busy_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |=> !busy_err_o);
endmodule

// File: tb/flash_window_seq_bench.sv
module flash_window_seq_bench;
  localparam int NUM_CS = 4;
  localparam int WIN_BITS = 27;
  localparam int MAX_BYTES = 8;
  localparam int ADDR_W = WIN_BITS + 2;
  localparam int LEN_W = 3;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_we = 1'b0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic [31:0]       rd_cfg = '0;
  logic [31:0]       wr_cfg = '0;
  logic              shared_busy = 1'b0;
  logic              xfer_start;
  logic [7:0]        xfer_tx;
  logic              xfer_done = 1'b0;
  logic [7:0]        xfer_rx = '0;
  logic [NUM_CS-1:0] cs_n;
  logic              addr_err, busy_err;

  flash_window_seq #(.NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS), .MAX_BYTES(MAX_BYTES)) u_flash_window_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rd_cfg_i(rd_cfg), .wr_cfg_i(wr_cfg), .shared_cs_busy_i(shared_busy),
    .xfer_start_o(xfer_start), .xfer_tx_o(xfer_tx), .xfer_done_i(xfer_done),
    .xfer_rx_i(xfer_rx), .cs_n_o(cs_n), .addr_err_o(addr_err), .busy_err_o(busy_err)
  );

  int checks = 0;
  int failures = 0;
  int lat_g = 1;
  int frame_cnt = 0;
  logic [7:0]        exp_tx_q[$];
  logic [NUM_CS-1:0] exp_cs_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flash-side monitor and responder: pops the expected wire stream
  initial begin
    forever begin
      if (rst_ni && xfer_start) begin
        if (exp_tx_q.size() == 0) begin
          check(1'b0, "R9", "unexpected start", 64'(xfer_tx), 64'h0);
        end else begin
          logic [7:0] et;
          logic [NUM_CS-1:0] ec;
          et = exp_tx_q.pop_front();
          ec = exp_cs_q.pop_front();
          check(xfer_tx == et, "R3", "wire byte", 64'(xfer_tx), 64'(et));
          check(cs_n == ec, "R2", "select during byte", 64'(cs_n), 64'(ec));
        end
        for (int k = 0; k < lat_g; k++) begin
          @(posedge clk); #1;
          if (xfer_start) check(1'b0, "R9", "start before done", 64'h1, 64'h0);
        end
        xfer_done = 1'b1;
        xfer_rx = 8'h3C + 8'(frame_cnt);
        frame_cnt++;
        @(posedge clk); #1;
        xfer_done = 1'b0;
      end else begin
        @(posedge clk); #1;
      end
    end
  end

  task automatic access(input int cs, input logic [26:0] off, input int nbytes,
                        input bit we, input logic [63:0] wd,
                        input logic [31:0] rcfg, input logic [31:0] wcfg,
                        input bit busy, input int lat, input string req);
    logic [31:0] cfg;
    logic [31:0] a32;
    logic [NUM_CS-1:0] ecs;
    logic [63:0] erd;
    int ab, dm, guard;
    bit bad;
    cfg = we ? wcfg : rcfg;
    a32 = 32'(off);
    ecs = ~(NUM_CS'(1) << cs);
    bad = cfg[17:16] > 2'd1;
    ab  = (cfg[17:16] == 2'd0) ? 3 : (cfg[17:16] == 2'd1) ? 4 : 0;
    dm  = we ? 0 : ((int'(rcfg[13:12]) * 8) >> rcfg[9:8]);
    exp_tx_q.push_back(cfg[7:0]); exp_cs_q.push_back(ecs);
    for (int i = ab - 1; i >= 0; i--) begin
      exp_tx_q.push_back(a32[8*i +: 8]); exp_cs_q.push_back(ecs);
    end
    for (int i = 0; i < dm; i++) begin
      exp_tx_q.push_back(8'h00); exp_cs_q.push_back(ecs);
    end
    for (int i = 0; i < nbytes; i++) begin
      exp_tx_q.push_back(we ? wd[8*i +: 8] : 8'h00); exp_cs_q.push_back(ecs);
    end
    erd = '0;
    if (!we) for (int i = 0; i < nbytes; i++) erd[8*i +: 8] = 8'h3C + 8'(1 + ab + dm + i);

    rd_cfg = rcfg; wr_cfg = wcfg; lat_g = lat; frame_cnt = 0;
    req_addr = {2'(cs), off}; req_len = 3'(nbytes - 1); req_we = we;
    req_wdata = wd; shared_busy = busy; req_valid = 1'b1;
    check(req_ready == 1'b1, "R10", "ready before request", 64'(req_ready), 64'h1);
    @(posedge clk); #1;
    req_valid = 1'b0; shared_busy = 1'b0;
    check(addr_err == bad, "R4", "addr_err pulse", 64'(addr_err), 64'(bad));
    check(busy_err == busy, "R8", "busy_err pulse", 64'(busy_err), 64'(busy));
    check(req_ready == 1'b0, "R10", "ready after accept", 64'(req_ready), 64'h0);
    guard = 0;
    while (!rsp_valid && guard < 2000) begin
      @(posedge clk); #1;
      guard++;
    end
    check(rsp_valid == 1'b1, "R10", "response seen", 64'(rsp_valid), 64'h1);
    check(rsp_rdata == erd, req, "response data (R7)", rsp_rdata, erd);
    check(cs_n == {NUM_CS{1'b1}}, "R2", "select released", 64'(cs_n), 64'hF);
    check(exp_tx_q.size() == 0, "R9", "bytes left unsent", 64'(exp_tx_q.size()), 64'h0);
    exp_tx_q.delete(); exp_cs_q.delete();
    @(posedge clk); #1;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "single response then idle",
          64'({rsp_valid, req_ready}), 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 64'h0, 64'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check(cs_n == {NUM_CS{1'b1}}, "R1", "reset cs_n", 64'(cs_n), 64'hF);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    check(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0 && xfer_start == 1'b0, "R1", "reset idle outputs",
          64'({rsp_valid, xfer_start}), 64'h0);
    check(cs_n == {NUM_CS{1'b1}}, "R1", "cs_n after reset", 64'(cs_n), 64'hF);

    // R3 R5: 3-byte address, 8 dummies, 4 bytes, window 0
    access(0, 27'h012_3456, 4, 1'b0, '0, 32'h0000_100B, 32'h0000_0002, 1'b0, 1, "R3");
    // R4 R5: 4-byte address, dummies 16>>2=4, 8 bytes unaligned, window 2
    access(2, 27'h5AB_CDE1, 8, 1'b0, '0, 32'h0001_220C, 32'h0000_0002, 1'b0, 2, "R4");
    // R5: dummies 24>>3=3, single byte, window 3
    access(3, 27'h000_0007, 1, 1'b0, '0, 32'h0000_3303, 32'h0000_0002, 1'b0, 3, "R5");
    // R5: no dummy when width field is 0, window 1
    access(1, 27'h7FF_FFFF, 2, 1'b0, '0, 32'h0000_0103, 32'h0000_0002, 1'b0, 1, "R5");
    // R6 R7: write, 3-byte address, 5 bytes
    access(1, 27'h00A_BC01, 5, 1'b1, 64'h0000_0055_4433_2211, 32'h0000_3008, 32'h0000_0002, 1'b0, 1, "R6");
    // R6: write 4-byte address, rd_cfg has dummies which must not appear
    access(3, 27'h412_3458, 8, 1'b1, 64'h8877_6655_4433_2211, 32'h0000_3003, 32'h0001_0012, 1'b0, 2, "R6");
    // R4: bad code 2 on read, no address bytes
    access(0, 27'h111_1111, 3, 1'b0, '0, 32'h0002_100B, 32'h0000_0002, 1'b0, 1, "R4");
    // R4: bad code 3 on write
    access(2, 27'h222_2222, 2, 1'b1, 64'h0000_0000_0000_BEEF, 32'h0000_100B, 32'h0003_0002, 1'b0, 1, "R4");
    // R8: collision flagged, transaction continues
    access(1, 27'h333_3333, 4, 1'b0, '0, 32'h0000_100B, 32'h0000_0002, 1'b1, 1, "R8");
    // R8: collision on a write
    access(0, 27'h044_0044, 1, 1'b1, 64'h0000_0000_0000_00A7, 32'h0000_100B, 32'h0000_0002, 1'b1, 3, "R8");
    // R7: back-to-back read after write, lanes cleared
    access(2, 27'h000_0100, 8, 1'b0, '0, 32'h0000_000B, 32'h0000_0002, 1'b0, 1, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule